// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a run of 16-bit words from a three-wire serial EEPROM. It drives chip select, a serial clock and a data-in line, and it samples the device's data-out line. The user issues a one-cycle start request with a byte address and a byte count. The block checks that both values are even, converts them to a first word address and a word total, and then reads the words one frame at a time.

Each frame begins with the device deselected. The block raises chip select and gives one dummy clock pulse. It then shifts out a 3-bit read opcode and a 6-bit word address, and clocks in 16 data bits. It drops chip select at the end of every word, so the next word gets a fresh frame at the next address. Each word is handed back as two bytes, low byte first, each marked by a one-cycle valid strobe. The length of each half of the serial clock is a parameter counted in system clock cycles.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, chip select, serial clock, data-in, busy, error and byte valid are all low. In every frame, chip select spends one bit phase low and one phase high with the clock low. One dummy clock pulse with chip select high then precedes the first command bit, and the serial clock is never high while chip select is low.
- R2: After the dummy pulse the block sends the read opcode 3'b110 and then the 6-bit word address, both most significant bit first. The EEPROM captures each bit on a rising clock edge.
- R3: Data-in changes only while the serial clock is low, so it holds steady for the whole of every high phase.
- R4: The block reads 16 data bits, most significant first. Each bit is sampled at the end of a clock-high phase. A complete frame therefore has exactly 26 rising clock edges: 1 dummy, 9 command and address, and 16 data.
- R5: Chip select falls after every word. The next word uses the next word address, wrapping from 63 to 0, inside a new frame.
- R6: Each word comes out as two bytes on consecutive cycles with byte valid high: bits 7:0 first, then bits 15:8.
- R7: The word address is the byte address divided by two, and the number of words is the byte count divided by two. A byte count of zero starts nothing.
- R8: Every high phase and every low phase of the serial clock lasts exactly PHASE_CYCLES system clock cycles.
- R9: Busy rises on the cycle after an accepted start and stays high until after the last byte has been delivered. A start request while busy has no effect on the transfer, the frames or the error flag.
- R10: A start request with an odd byte address or an odd byte count sets the error flag and starts no transfer. The next accepted start clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle read request |
| byte_addr_i | input | 7 | Starting byte address (must be even) |
| byte_count_i | input | 8 | Number of bytes to read (must be even) |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Last request was rejected as odd |
| byte_valid_o | output | 1 | Strobe for byte_o |
| byte_o | output | 8 | Returned byte, low byte of each word first |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
The embedded assertions check these properties on every cycle:
- data-in holds steady through each clock-high phase;
- the serial clock is never high without chip select;
- the high phase lasts exactly the set number of cycles;
- the high byte directly follows every low byte;
- a byte is never delivered outside busy;
- an odd request raises the error flag without starting a transfer.

Only the bench's EEPROM responder can confirm the parts that depend on a device at the other end of the wires. These are the opcode and address bits as captured, the 26-edge frame, the address increment and wrap across frames, the byte order against the stored words, and a start request being ignored in the middle of a transfer.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  localparam int CMD_BITS = 3;
  localparam logic [CMD_BITS-1:0] READ_OPCODE = 3'b110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DESEL,
    ST_SELECT,
    ST_DUMMY,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_DAT_LO,
    ST_DAT_HI,
    ST_FINISH
  } seq_state_t;

endpackage

// File: rtl/bit_phase_timer.sv
module bit_phase_timer #(
  parameter int PHASE_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/uwire_read_sequencer.sv
module uwire_read_sequencer
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_BITS    = 6,
  parameter int DATA_BITS    = 16,
  parameter int PHASE_CYCLES = 100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 go,
  input  logic [ADDR_BITS-1:0] first_word,
  input  logic [ADDR_BITS:0]   num_words,
  output logic                 active,
  output logic                 cs_o,
  output logic                 sk_o,
  output logic                 di_o,
  input  logic                 so_i,
  output logic                 word_valid,
  output logic [DATA_BITS-1:0] word
);
  localparam int SHIFT_LEN = CMD_BITS + ADDR_BITS;
  localparam int BIT_W     = $clog2((SHIFT_LEN > DATA_BITS) ? SHIFT_LEN : DATA_BITS);
  localparam logic [BIT_W-1:0] LAST_CMD = BIT_W'(SHIFT_LEN - 1);
  localparam logic [BIT_W-1:0] LAST_DAT = BIT_W'(DATA_BITS - 1);

  seq_state_t st_q, st_n;
  logic [SHIFT_LEN-1:0] cmd_q, cmd_n;
  logic [DATA_BITS-1:0] dat_q, dat_n;
  logic [BIT_W-1:0]     bit_q, bit_n;
  logic [ADDR_BITS-1:0] wa_q, wa_n;
  logic [ADDR_BITS:0]   left_q, left_n;
  logic                 wv_n;

  always_comb begin
    st_n   = st_q;
    cmd_n  = cmd_q;
    dat_n  = dat_q;
    bit_n  = bit_q;
    wa_n   = wa_q;
    left_n = left_q;
    wv_n   = 1'b0;
    case (st_q)
      ST_IDLE: if (go) begin
        st_n   = ST_DESEL;
        wa_n   = first_word;
        left_n = num_words;
        cmd_n  = {READ_OPCODE, first_word};
      end
      ST_DESEL:  if (tick) st_n = ST_SELECT;
      ST_SELECT: if (tick) st_n = ST_DUMMY;
      ST_DUMMY:  if (tick) begin
        st_n  = ST_CMD_LO;
        bit_n = '0;
      end
      ST_CMD_LO: if (tick) st_n = ST_CMD_HI;
      ST_CMD_HI: if (tick) begin
        if (bit_q == LAST_CMD) begin
          st_n  = ST_DAT_LO;
          bit_n = '0;
        end else begin
          st_n  = ST_CMD_LO;
          bit_n = bit_q + 1'b1;
          cmd_n = {cmd_q[SHIFT_LEN-2:0], 1'b0};
        end
      end
      ST_DAT_LO: if (tick) st_n = ST_DAT_HI;
      ST_DAT_HI: if (tick) begin
        dat_n = {dat_q[DATA_BITS-2:0], so_i};
        if (bit_q == LAST_DAT) begin
          st_n = ST_FINISH;
          wv_n = 1'b1;
        end else begin
          st_n  = ST_DAT_LO;
          bit_n = bit_q + 1'b1;
        end
      end
      ST_FINISH: if (tick) begin
        if (left_q == 1) begin
          st_n = ST_IDLE;
        end else begin
          st_n   = ST_DESEL;
          left_n = left_q - 1'b1;
          wa_n   = wa_q + 1'b1;
          cmd_n  = {READ_OPCODE, wa_q + 1'b1};
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cmd_q      <= '0;
      dat_q      <= '0;
      bit_q      <= '0;
      wa_q       <= '0;
      left_q     <= '0;
      word_valid <= 1'b0;
      cs_o       <= 1'b0;
      sk_o       <= 1'b0;
      di_o       <= 1'b0;
    end else begin
      st_q       <= st_n;
      cmd_q      <= cmd_n;
      dat_q      <= dat_n;
      bit_q      <= bit_n;
      wa_q       <= wa_n;
      left_q     <= left_n;
      word_valid <= wv_n;
      cs_o       <= !(st_n inside {ST_IDLE, ST_DESEL});
      sk_o       <= st_n inside {ST_DUMMY, ST_CMD_HI, ST_DAT_HI};
      di_o       <= (st_n inside {ST_CMD_LO, ST_CMD_HI}) ? cmd_n[SHIFT_LEN-1] : 1'b0;
    end
  end

  assign active = (st_q != ST_IDLE);
  assign word   = dat_q;

  // Length of the current clock-high stretch, watched by the R8 check.
  logic [$clog2(PHASE_CYCLES+2)-1:0] hi_len_q;
  always_ff @(posedge clk) begin
    if (rst || !sk_o) hi_len_q <= '0;
    else if (hi_len_q <= PHASE_CYCLES) hi_len_q <= hi_len_q + 1'b1;
  end

  a_r3_di_steady_while_high: assert property (@(posedge clk) disable iff (rst)
    (sk_o && $past(sk_o)) |-> $stable(di_o));

  a_r1_clock_needs_select: assert property (@(posedge clk) disable iff (rst)
    sk_o |-> cs_o);

  a_r8_high_phase_length: assert property (@(posedge clk) disable iff (rst)
    $fell(sk_o) |-> (hi_len_q == PHASE_CYCLES));

endmodule

// File: rtl/word_byte_splitter.sv
module word_byte_splitter #(
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 word_valid,
  input  logic [DATA_BITS-1:0] word,
  output logic                 byte_valid,
  output logic [7:0]           byte_out
);
  logic       pend_q;
  logic [7:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      hi_q       <= '0;
      byte_valid <= 1'b0;
      byte_out   <= '0;
    end else if (word_valid) begin
      byte_out   <= word[7:0];
      hi_q       <= word[15:8];
      pend_q     <= 1'b1;
      byte_valid <= 1'b1;
    end else if (pend_q) begin
      byte_out   <= hi_q;
      pend_q     <= 1'b0;
      byte_valid <= 1'b1;
    end else begin
      byte_valid <= 1'b0;
    end
  end

  a_r6_two_bytes_per_word: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> (byte_valid ##1 byte_valid));

endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader #(
  parameter int ADDR_BITS    = 6,
  parameter int DATA_BITS    = 16,
  parameter int PHASE_CYCLES = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [ADDR_BITS:0] byte_addr_i,
  input  logic [ADDR_BITS+1:0] byte_count_i,
  output logic               busy_o,
  output logic               err_o,
  output logic               byte_valid_o,
  output logic [7:0]         byte_o,
  output logic               ee_cs_o,
  output logic               ee_sk_o,
  output logic               ee_di_o,
  input  logic               ee_do_i
);
  initial begin
    if (PHASE_CYCLES < 3) $error("PHASE_CYCLES must be at least 3");
  end

  logic                 tick, active, go, odd_req;
  logic                 word_valid;
  logic [DATA_BITS-1:0] word;

  assign odd_req = byte_addr_i[0] || byte_count_i[0];
  assign go      = start_i && !active && !odd_req && (byte_count_i != '0);

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else if (start_i && !active) begin
      if (odd_req) err_o <= 1'b1;
      else if (go) err_o <= 1'b0;
    end
  end

  bit_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(active), .tick(tick)
  );

  uwire_read_sequencer #(
    .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS), .PHASE_CYCLES(PHASE_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .go(go),
    .first_word(byte_addr_i[ADDR_BITS:1]),
    .num_words(byte_count_i[ADDR_BITS+1:1]),
    .active(active), .cs_o(ee_cs_o), .sk_o(ee_sk_o), .di_o(ee_di_o),
    .so_i(ee_do_i), .word_valid(word_valid), .word(word)
  );

  word_byte_splitter #(.DATA_BITS(DATA_BITS)) u_split (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word(word),
    .byte_valid(byte_valid_o), .byte_out(byte_o)
  );

  assign busy_o = active;

  a_r9_bytes_only_while_busy: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> busy_o);

  a_r10_odd_rejected: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && odd_req) |=> (err_o && !busy_o));

endmodule

// File: tb/eeprom_word_reader_test.sv
module eeprom_word_reader_test;
  localparam int PH = 4;

  logic clk = 0, rst = 1, start = 0, so = 0;
  logic [6:0] baddr = 0;
  logic [7:0] bcount = 0;
  logic busy, err, bv, cs, sk, di;
  logic [7:0] bout;

  always #5 clk = ~clk;

  eeprom_word_reader #(.PHASE_CYCLES(PH)) uut (
    .clk(clk), .rst(rst), .start_i(start), .byte_addr_i(baddr),
    .byte_count_i(bcount), .busy_o(busy), .err_o(err), .byte_valid_o(bv),
    .byte_o(bout), .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(so)
  );

  int total = 0, bad = 0, cyc = 0;

  function automatic logic [15:0] rom(input logic [5:0] a);
    return {a, 2'b01, ~a, 2'b10};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural EEPROM responder
  int frames = 0, bad_len = 0, bad_cmd = 0, rise_n = 0;
  bit in_frame = 0;
  logic [2:0] cmd_acc;
  logic [5:0] addr_acc;
  logic [5:0] addr_log [0:63];
  always @(posedge sk or negedge cs) begin
    if (!cs) begin
      if (in_frame) begin
        if (rise_n != 26) bad_len++;
        if (cmd_acc != 3'b110) bad_cmd++;
        addr_log[frames % 64] = addr_acc;
        frames++;
      end
      in_frame = 0;
      rise_n = 0;
      so = 0;
    end else begin
      in_frame = 1;
      rise_n++;
      if (rise_n == 1) cmd_acc = 0;
      else if (rise_n <= 4) cmd_acc = {cmd_acc[1:0], di};
      else if (rise_n <= 10) addr_acc = {addr_acc[4:0], di};
      else if (rise_n <= 26) so = rom(addr_acc)[26 - rise_n];
    end
  end

  // monitors, sampled away from the active edge
  int nbytes = 0, di_bad = 0, hi_run = 0, width_bad = 0, sk_no_cs = 0;
  logic [7:0] bytes [0:255];
  int bcyc [0:255];
  logic prev_sk = 0, prev_di = 0;
  always @(negedge clk) begin
    cyc++;
    if (bv) begin
      bytes[nbytes % 256] = bout;
      bcyc[nbytes % 256] = cyc;
      nbytes++;
    end
    if (sk && prev_sk && di !== prev_di) di_bad++;
    if (sk && !cs) sk_no_cs++;
    if (sk) hi_run++;
    else begin
      if (prev_sk && hi_run != PH) width_bad++;
      hi_run = 0;
    end
    prev_sk = sk;
    prev_di = di;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(input int a, input int c);
    @(negedge clk);
    baddr = 7'(a); bcount = 8'(c); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_and_check(input int a, input int c, input string tag);
    int f0 = frames, b0 = nbytes;
    issue(a, c);
    check(busy === 1'b1, {tag, " R9 busy after start"}, busy, 1);
    wait_idle();
    check(nbytes - b0 == c, {tag, " R7 byte count"}, nbytes - b0, c);
    check(frames - f0 == c / 2, {tag, " R5 frame per word"}, frames - f0, c / 2);
    for (int w = 0; w < c / 2; w++) begin
      logic [5:0] wa = 6'(a / 2 + w);
      logic [15:0] exp = rom(wa);
      check(addr_log[(f0 + w) % 64] == wa, {tag, " R2 R5 word address"}, addr_log[(f0 + w) % 64], wa);
      check(bytes[(b0 + 2*w) % 256] == exp[7:0], {tag, " R6 low byte first"}, bytes[(b0 + 2*w) % 256], exp[7:0]);
      check(bytes[(b0 + 2*w + 1) % 256] == exp[15:8], {tag, " R4 R6 high byte"}, bytes[(b0 + 2*w + 1) % 256], exp[15:8]);
      check(bcyc[(b0 + 2*w + 1) % 256] == bcyc[(b0 + 2*w) % 256] + 1, {tag, " R6 consecutive"},
            bcyc[(b0 + 2*w + 1) % 256] - bcyc[(b0 + 2*w) % 256], 1);
    end
  endtask

  task automatic t_reset();
    check({cs, sk, di, busy, err, bv} == 6'b0, "R1 reset outputs low", {cs, sk, di, busy, err, bv}, 0);
  endtask

  task automatic t_single();  read_and_check(0, 2, "single");  endtask
  task automatic t_multi();   read_and_check(20, 8, "multi");  endtask
  task automatic t_wrap();    read_and_check(124, 6, "wrap");  endtask

  task automatic t_odd();
    int f0 = frames;
    issue(5, 4);
    check(err === 1'b1, "R10 odd address error", err, 1);
    check(busy === 1'b0, "R10 odd address no start", busy, 0);
    issue(4, 3);
    check(err === 1'b1, "R10 odd count error", err, 1);
    repeat (PH * 4) @(negedge clk);
    check(frames == f0 && !cs, "R10 no frame on odd request", frames - f0, 0);
    read_and_check(2, 2, "clear");
    check(err === 1'b0, "R10 error cleared by good start", err, 1'b0);
  endtask

  task automatic t_zero();
    int f0 = frames;
    issue(8, 0);
    repeat (PH * 4) @(negedge clk);
    check(busy === 1'b0 && frames == f0, "R7 zero count starts nothing", frames - f0, 0);
  endtask

  task automatic t_busy_ignore();
    int f0 = frames, b0 = nbytes;
    issue(40, 4);
    repeat (PH * 20) @(negedge clk);
    issue(10, 2);
    issue(11, 2);
    check(err === 1'b0, "R9 start while busy leaves error low", err, 0);
    wait_idle();
    check(frames - f0 == 2 && nbytes - b0 == 4, "R9 start while busy ignored", nbytes - b0, 4);
    check(addr_log[f0 % 64] == 20 && addr_log[(f0 + 1) % 64] == 21, "R9 addresses unchanged",
          addr_log[(f0 + 1) % 64], 21);
  endtask

  task automatic t_protocol();
    check(bad_len == 0, "R1 R4 26 clock rises per frame", bad_len, 0);
    check(bad_cmd == 0, "R2 read opcode 110", bad_cmd, 0);
    check(di_bad == 0, "R3 data-in steady while clock high", di_bad, 0);
    check(sk_no_cs == 0, "R1 clock only with select", sk_no_cs, 0);
    check(width_bad == 0, "R8 clock high phase length", width_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_wrap();
    t_odd();
    t_zero();
    t_busy_ignore();
    t_protocol();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule